// File: doc/BRIEF.md
# Staged Register Access Sequencer for a 16-bit Parallel USB Host Chip

This block converts one register request from an on-chip master into the chip-select sequence that an external USB host controller chip needs. The chip has a 16-bit parallel bus and two ports. A register number goes to the command port first. Register contents then move through the data port, in one 16-bit stage or in two 16-bit stages for a 32-bit register.

The master hands over a request on a valid/ready interface. The request carries a register number, a width flag, a direction flag and 32 bits of write data. The sequencer latches the request and runs a command stage, then the data stages. It holds chip select high for a programmable number of clocks after every stage, including the last one. When the sequence ends it raises a single-cycle completion pulse, which carries the read result on reads. Each stage lasts a fixed number of strobe clocks, and the idle gap is sized in clocks to cover the chip's minimum 300 ns recovery time.

Top module: `reg_stage_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, csN, rdN and wrN are high, busOe is low, done is low and reqReady is high.
- R2: The first stage after a request is accepted is a write to the command port (portAddr = 2'b01). Its bus value is the register number, zero-extended to 16 bits.
- R3: Every stage holds csN low for exactly STROBE_CYCLES clocks. Exactly one of rdN or wrN is low in each of those clocks, and neither strobe is ever low while csN is high.
- R4: Once csN has been low, it stays high for at least GAP_CYCLES clocks before it falls again. This applies between stages of one access and between the last stage of one access and the first stage of the next.
- R5: A 16-bit access has exactly one data stage on the data port (portAddr = 2'b00) after the command stage. The data stage is a write strobe for writes and a read strobe for reads.
- R6: A 32-bit access has two data stages. The first moves bits 15:0 and the second moves bits 31:16, for both reads and writes.
- R7: A read returns the bus value present in the last clock of each read strobe. For 16-bit reads, rdData[31:16] is zero.
- R8: busOe is high exactly in the clocks where wrN is low. The bus is released at all other times.
- R9: reqReady is low from the clock after acceptance until the clock after done. done lasts one clock, and it rises (stages × (STROBE_CYCLES + GAP_CYCLES) + 1) clocks after acceptance.
- R10: Whenever csN is low, portAddr[1] is zero, so the device controller ports on the shared chip select are never addressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Sequencer idle and able to accept |
| reqAddr | input | ADDR_W | Register number sent in the command stage |
| reqWide | input | 1 | 1 = 32-bit register, 0 = 16-bit |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data (bits 15:0 used for 16-bit writes) |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read result, valid with done on reads |
| csN | output | 1 | Active-low chip select |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |
| portAddr | output | 2 | Port select lines: 01 command, 00 data |
| busOut | output | 16 | Bus value to drive |
| busOe | output | 1 | Bus output enable (0 = high impedance) |
| busIn | input | 16 | Bus value from the chip |

## Verification
The bench models the chip. Its read data is inverted on every strobe clock except the last, so a design that samples early or late returns inverted data. The model stores the halves of a 32-bit register separately, so a design that swaps the halves shows up as a mismatch both in the model's storage and in the read-back. The bench measures every chip-select high run against the gap, including the gap that closes an access. A design that shortens the gap after the final stage, or that accepts a back-to-back request too early, fails there. It also checks the exact completion latency and that ready stays low for the whole access.

// File: rtl/reg_stage_pkg.sv
package reg_stage_pkg;

  typedef enum logic [1:0] {
    STG_CMD = 2'd0,
    STG_LO  = 2'd1,
    STG_HI  = 2'd2
  } stage_e;

  // strobes from control to datapath
  typedef struct packed {
    logic   capture;   // latch request this cycle
    logic   active;    // a stage is on the bus (chip select low)
    stage_e stage;     // which stage is active / last active
    logic   sampleLo;  // capture read data into bits 15:0
    logic   sampleHi;  // capture read data into bits 31:16
    logic   finish;    // completion cycle
  } seqCtl_t;

  localparam logic [1:0] PORT_CMD  = 2'b01;
  localparam logic [1:0] PORT_DATA = 2'b00;

endpackage

// File: rtl/reg_stage_ctrl.sv
module reg_stage_ctrl
  import reg_stage_pkg::*;
#(
  parameter int STROBE_CYCLES = 2,
  parameter int GAP_CYCLES    = 75
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    reqValid,
  input  logic    isWide,
  input  logic    isWrite,
  output logic    reqReady,
  output seqCtl_t ctl
);

  localparam int CNT_MAX = (GAP_CYCLES > STROBE_CYCLES) ? GAP_CYCLES : STROBE_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] STRB_LOAD = CNT_W'(STROBE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(GAP_CYCLES - 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_GAP  = 2'd2,
    ST_FIN  = 2'd3
  } state_e;

  state_e            state;
  stage_e            stage;
  logic [CNT_W-1:0]  cnt;
  logic              accept;
  logic              lastTick;

  assign accept   = reqValid && (state == ST_IDLE);
  assign lastTick = (cnt == '0);
  assign reqReady = (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      stage <= STG_CMD;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state <= ST_STRB;
            stage <= STG_CMD;
            cnt   <= STRB_LOAD;
          end
        end
        ST_STRB: begin
          if (lastTick) begin
            state <= ST_GAP;
            cnt   <= GAP_LOAD;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_GAP: begin
          if (!lastTick) begin
            cnt <= cnt - 1'b1;
          end else if (stage == STG_CMD) begin
            state <= ST_STRB;
            stage <= STG_LO;
            cnt   <= STRB_LOAD;
          end else if (stage == STG_LO && isWide) begin
            state <= ST_STRB;
            stage <= STG_HI;
            cnt   <= STRB_LOAD;
          end else begin
            state <= ST_FIN;
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
          stage <= STG_CMD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl          = '0;
    ctl.capture  = accept;
    ctl.active   = (state == ST_STRB);
    ctl.stage    = stage;
    ctl.sampleLo = ctl.active && (stage == STG_LO) && lastTick && !isWrite;
    ctl.sampleHi = ctl.active && (stage == STG_HI) && lastTick && !isWrite;
    ctl.finish   = (state == ST_FIN);
  end

endmodule

// File: rtl/reg_stage_dpath.sv
module reg_stage_dpath
  import reg_stage_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWide,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  input  logic [15:0]       busIn,
  output logic              isWide,
  output logic              isWrite,
  output logic              csN,
  output logic              rdN,
  output logic              wrN,
  output logic [1:0]        portAddr,
  output logic [15:0]       busOut,
  output logic              busOe,
  output logic [31:0]       rdData,
  output logic              done
);

  logic [15:0] cmdWord;
  logic [15:0] cmdLat;
  logic [31:0] wdLat;
  logic        isCmd;
  logic        wrActive;

  // zero-extend the register number to the bus width
  generate
    if (ADDR_W < 16) begin : g_ext
      assign cmdWord = {{(16 - ADDR_W){1'b0}}, reqAddr};
    end else begin : g_trim
      assign cmdWord = reqAddr[15:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdLat  <= '0;
      wdLat   <= '0;
      isWide  <= 1'b0;
      isWrite <= 1'b0;
    end else if (ctl.capture) begin
      cmdLat  <= cmdWord;
      wdLat   <= reqWdata;
      isWide  <= reqWide;
      isWrite <= reqWrite;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdData <= '0;
    end else begin
      if (ctl.sampleLo) begin
        rdData <= {16'h0000, busIn};
      end
      if (ctl.sampleHi) begin
        rdData[31:16] <= busIn;
      end
    end
  end

  assign isCmd    = (ctl.stage == STG_CMD);
  assign wrActive = ctl.active && (isCmd || isWrite);

  assign csN      = !ctl.active;
  assign wrN      = !wrActive;
  assign rdN      = !(ctl.active && !isCmd && !isWrite);
  assign portAddr = isCmd ? PORT_CMD : PORT_DATA;
  assign busOe    = wrActive;
  assign done     = ctl.finish;

  always_comb begin
    unique case (ctl.stage)
      STG_CMD: busOut = cmdLat;
      STG_HI:  busOut = wdLat[31:16];
      default: busOut = wdLat[15:0];
    endcase
  end

endmodule

// File: rtl/reg_stage_seq.sv
module reg_stage_seq
  import reg_stage_pkg::*;
#(
  parameter int ADDR_W        = 8,
  parameter int STROBE_CYCLES = 2,
  parameter int GAP_CYCLES    = 75
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWide,
  input  logic              reqWrite,
  input  logic [31:0]       reqWdata,
  output logic              done,
  output logic [31:0]       rdData,
  output logic              csN,
  output logic              rdN,
  output logic              wrN,
  output logic [1:0]        portAddr,
  output logic [15:0]       busOut,
  output logic              busOe,
  input  logic [15:0]       busIn
);

  seqCtl_t ctl;
  logic    isWide;
  logic    isWrite;

  reg_stage_ctrl #(
    .STROBE_CYCLES (STROBE_CYCLES),
    .GAP_CYCLES    (GAP_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .isWide   (isWide),
    .isWrite  (isWrite),
    .reqReady (reqReady),
    .ctl      (ctl)
  );

  reg_stage_dpath #(
    .ADDR_W (ADDR_W)
  ) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWide  (reqWide),
    .reqWrite (reqWrite),
    .reqWdata (reqWdata),
    .busIn    (busIn),
    .isWide   (isWide),
    .isWrite  (isWrite),
    .csN      (csN),
    .rdN      (rdN),
    .wrN      (wrN),
    .portAddr (portAddr),
    .busOut   (busOut),
    .busOe    (busOe),
    .rdData   (rdData),
    .done     (done)
  );

endmodule

// File: rtl/reg_stage_seq_chk.sv
module reg_stage_seq_chk #(
  parameter int STROBE_CYCLES = 2,
  parameter int GAP_CYCLES    = 75
) (
  input logic       clk,
  input logic       rst,
  input logic       reqValid,
  input logic       reqReady,
  input logic       done,
  input logic       csN,
  input logic       rdN,
  input logic       wrN,
  input logic [1:0] portAddr,
  input logic       busOe
);

  logic [15:0] hiRun;
  logic [15:0] loRun;
  logic        seenLow;

  always_ff @(posedge clk) begin
    if (rst) begin
      hiRun   <= '0;
      loRun   <= '0;
      seenLow <= 1'b0;
    end else begin
      if (csN) begin
        loRun <= '0;
        if (hiRun != 16'hFFFF) hiRun <= hiRun + 1'b1;
      end else begin
        hiRun   <= '0;
        seenLow <= 1'b1;
        if (loRun != 16'hFFFF) loRun <= loRun + 1'b1;
      end
    end
  end

  // R1: outputs idle right after reset
  a_r1_reset_idle: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (csN && rdN && wrN && !busOe && reqReady && !done));

  // R3: never both strobes, strobes only inside chip select
  a_r3_one_strobe: assert property (@(posedge clk) disable iff (rst)
    !(!rdN && !wrN));
  a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (rst)
    (!rdN || !wrN) |-> !csN);
  a_r3_stage_width: assert property (@(posedge clk) disable iff (rst)
    ($rose(csN) && seenLow) |-> (loRun == 16'(STROBE_CYCLES)));

  // R4: idle gap before every new stage
  a_r4_gap_kept: assert property (@(posedge clk) disable iff (rst)
    ($fell(csN) && seenLow) |-> (hiRun >= 16'(GAP_CYCLES)));

  // R8: bus never driven during a read strobe or while deselected
  a_r8_bus_released: assert property (@(posedge clk) disable iff (rst)
    (csN || !rdN) |-> !busOe);

  // R9: handshake
  a_r9_accept_starts: assert property (@(posedge clk) disable iff (rst)
    (reqValid && reqReady) |=> (!csN && !reqReady));
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && reqReady));
  a_r9_busy_on_done: assert property (@(posedge clk) disable iff (rst)
    done |-> !reqReady);

  // R10: device controller ports never addressed
  a_r10_host_port: assert property (@(posedge clk) disable iff (rst)
    !csN |-> (portAddr[1] == 1'b0));

endmodule

bind reg_stage_seq reg_stage_seq_chk #(
  .STROBE_CYCLES (STROBE_CYCLES),
  .GAP_CYCLES    (GAP_CYCLES)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .reqValid (reqValid),
  .reqReady (reqReady),
  .done     (done),
  .csN      (csN),
  .rdN      (rdN),
  .wrN      (wrN),
  .portAddr (portAddr),
  .busOe    (busOe)
);

// File: tb/reg_stage_seq_tb_top.sv
`timescale 1ns/1ps
module reg_stage_seq_tb_top;

  localparam int ADDR_W = 8;
  localparam int SC     = 2;
  localparam int GC     = 75;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWide = 1'b0;
  logic              reqWrite = 1'b0;
  logic [31:0]       reqWdata = '0;
  logic              done;
  logic [31:0]       rdData;
  logic              csN, rdN, wrN, busOe;
  logic [1:0]        portAddr;
  logic [15:0]       busOut;
  logic [15:0]       busIn;

  always #2 clk = ~clk;  // 250 MHz

  reg_stage_seq #(
    .ADDR_W (ADDR_W), .STROBE_CYCLES (SC), .GAP_CYCLES (GC)
  ) dut_i (
    .clk (clk), .rst (rst), .reqValid (reqValid), .reqReady (reqReady),
    .reqAddr (reqAddr), .reqWide (reqWide), .reqWrite (reqWrite),
    .reqWdata (reqWdata), .done (done), .rdData (rdData), .csN (csN),
    .rdN (rdN), .wrN (wrN), .portAddr (portAddr), .busOut (busOut),
    .busOe (busOe), .busIn (busIn)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // chip model and reference memory: register n -> words 2n (low), 2n+1 (high)
  logic [15:0] chipMem [512];
  logic [15:0] refMem  [512];
  logic [7:0]  curAddr = '0;
  logic [1:0]  dStg = '0;
  int          rdRun = 0;
  logic [8:0]  memIdx;

  assign memIdx = {curAddr, dStg[0]};
  assign busIn  = (rdRun == SC) ? chipMem[memIdx] : ~chipMem[memIdx];

  // stage recorder
  int          stgCnt = 0;
  logic [1:0]  stgPort [4];
  bit          stgWr   [4];
  logic [15:0] stgVal  [4];
  int          loRun = 0, hiRun = 0;
  bit          seenStage = 1'b0;
  bit          prevCs = 1'b1;
  bit          strobeBad = 1'b0;
  bit          curWr = 1'b0;
  logic [1:0]  curPort = '0;
  logic [15:0] curVal = '0;

  always @(negedge clk) begin
    if (!rst) begin
      chk(busOe == !wrN, "R8 busOe vs wrN", {31'b0, busOe}, {31'b0, !wrN});
      if (!csN) begin
        if (prevCs) begin
          chk(!seenStage || hiRun >= GC, "R4 cs high gap", hiRun, GC);
          loRun = 0;
          strobeBad = 1'b0;
          curWr = !wrN;
          curPort = portAddr;
        end
        loRun++;
        if ((rdN == wrN) || (curWr != !wrN)) strobeBad = 1'b1;
        if (portAddr[1]) strobeBad = 1'b1;
        if (!wrN) curVal = busOut;
        if (!rdN) rdRun++;
        hiRun = 0;
      end else begin
        if (!prevCs) begin
          seenStage = 1'b1;
          chk(loRun == SC, "R3 stage width", loRun, SC);
          chk(!strobeBad, "R3/R10 single strobe and host port", {31'b0, strobeBad}, 0);
          if (stgCnt < 4) begin
            stgPort[stgCnt] = curPort;
            stgWr[stgCnt]   = curWr;
            stgVal[stgCnt]  = curVal;
          end
          stgCnt++;
          if (curPort == 2'b01 && curWr) begin
            curAddr = curVal[7:0];
            dStg = 0;
          end else if (curPort == 2'b00) begin
            if (curWr) chipMem[{curAddr, dStg[0]}] = curVal;
            dStg++;
          end
          rdRun = 0;
        end else if (!(!rdN || !wrN)) begin
          chk(1'b1, "R3", 0, 0);
        end
        if (!rdN || !wrN) chk(1'b0, "R3 strobe outside cs", {rdN, wrN}, 2'b11);
        hiRun++;
      end
      prevCs = csN;
    end
  end

  task automatic access(input logic [7:0] a, input bit wide, input bit wr,
                        input logic [31:0] wd);
    int k;
    int nst;
    logic [31:0] expRd;
    bit busyOk;
    nst = wide ? 3 : 2;
    do @(negedge clk); while (!reqReady);
    stgCnt = 0;
    reqValid = 1'b1; reqAddr = a; reqWide = wide; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    reqWdata = ~wd;
    reqAddr = ~a;
    k = 1;
    busyOk = 1'b1;
    while (!done && k < 5000) begin
      if (reqReady) busyOk = 1'b0;
      @(negedge clk);
      k++;
    end
    chk(busyOk && !reqReady, "R9 ready low while busy", {31'b0, busyOk}, 1);
    chk(k == nst * (SC + GC) + 1, "R9 done latency", k, nst * (SC + GC) + 1);
    chk(stgCnt == nst, "R5/R6 stage count", stgCnt, nst);
    chk(stgPort[0] == 2'b01 && stgWr[0] && stgVal[0] == {8'h00, a},
        "R2 command stage", {stgPort[0], 13'b0, stgWr[0], stgVal[0]},
        {2'b01, 13'b0, 1'b1, 8'h00, a});
    chk(stgPort[1] == 2'b00 && stgWr[1] == wr, "R5 first data stage",
        {stgPort[1], stgWr[1]}, {2'b00, wr});
    if (wide) chk(stgPort[2] == 2'b00 && stgWr[2] == wr, "R6 second data stage",
                  {stgPort[2], stgWr[2]}, {2'b00, wr});
    if (wr) begin
      refMem[{a, 1'b0}] = wd[15:0];
      if (wide) refMem[{a, 1'b1}] = wd[31:16];
      chk(stgVal[1] == wd[15:0], "R5/R6 low half written first", stgVal[1], wd[15:0]);
      if (wide) chk(stgVal[2] == wd[31:16], "R6 high half written second",
                    stgVal[2], wd[31:16]);
      chk({chipMem[{a, 1'b1}], chipMem[{a, 1'b0}]} == {refMem[{a, 1'b1}], refMem[{a, 1'b0}]},
          "R6 chip contents", {chipMem[{a, 1'b1}], chipMem[{a, 1'b0}]},
          {refMem[{a, 1'b1}], refMem[{a, 1'b0}]});
    end else begin
      expRd = wide ? {refMem[{a, 1'b1}], refMem[{a, 1'b0}]} : {16'h0000, refMem[{a, 1'b0}]};
      chk(rdData == expRd, "R7 read data", rdData, expRd);
    end
    @(negedge clk);
    chk(!done && reqReady, "R9 done one cycle", {done, reqReady}, 2'b01);
  endtask

  initial begin
    void'($urandom(32'd4771));
    for (int i = 0; i < 512; i++) begin
      chipMem[i] = 16'($urandom);
      refMem[i]  = chipMem[i];
    end
    repeat (4) @(negedge clk);
    chk(csN && rdN && wrN && !busOe && !done && reqReady, "R1 during reset",
        {csN, rdN, wrN, busOe, done, reqReady}, 6'b111001);
    rst = 1'b0;
    @(negedge clk);
    chk(csN && rdN && wrN && !busOe && !done && reqReady, "R1 after reset",
        {csN, rdN, wrN, busOe, done, reqReady}, 6'b111001);

    access(8'h00, 1'b0, 1'b1, 32'hFFFF_A55A);   // R5 16-bit write
    access(8'h00, 1'b0, 1'b0, 32'h0);           // R7 16-bit read, upper zero
    access(8'hFF, 1'b1, 1'b1, 32'hDEAD_BEEF);   // R6 32-bit write
    access(8'hFF, 1'b1, 1'b0, 32'h0);           // R6 32-bit read
    access(8'h3C, 1'b1, 1'b0, 32'h0);           // R7 preset contents
    access(8'h3C, 1'b0, 1'b0, 32'h0);
    for (int n = 0; n < 200; n++) begin
      access(8'($urandom_range(0, 255)), 1'($urandom), 1'($urandom), $urandom);
    end
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule